// File: doc/BRIEF.md
# Dual-Path Divider Configuration Loader

This block keeps the programming values of a clock synthesizer (a 9-bit feedback value M, a 3-bit output divider code N and a 2-bit test selector T). It also runs the digital output divider that those values control. The values can be written in two ways. A parallel strobe captures M and N from pins. A serial interface shifts a 14-bit frame into a holding register, and a separate load control copies that frame into the configuration registers. Both paths write the same registers. The most recent write wins.

The output divider counts ticks from one of two sources. In PLL mode it uses the PLL clock tick. In bypass mode it uses the selected reference tick (crystal or external). Its output toggles once per 2^N source ticks. A master reset clears the divider and forces the output pair to low/high. It leaves the loaded configuration alone. A test output shows one internal signal chosen by T, but only after a serial load. All strobe and serial inputs are asynchronous to `clk` and are synchronized inside the block.

Top module: `cfg_synth_loader`

## Requirements
- R1: A rising edge on the active-low `pload_n_i` copies `m_i` into `m_o` and `n_i` into `n_o`. It leaves `t_o` unchanged.
- R2: Each rising edge of `sclk_i` shifts `sdata_i` into a 14-bit holding register, first bit first. After 14 bits the frame reads T[1:0], N[2:0], M[8:0] from first bit to last, so the last bit lands in M[0]. A rising edge of `sload_i` copies the frame into `t_o`, `n_o` and `m_o`.
- R3: Serial shifting without a rising edge of `sload_i` leaves `m_o`, `n_o` and `t_o` unchanged.
- R4: While `mr_i` is high, from the cycle after it rises, `fout_o` is 0 and `fout_n_o` is 1. Master reset does not change `m_o`, `n_o` or `t_o`.
- R5: Once `mr_i` is low, `fout_o` toggles after every 2^N source ticks, where N is `n_o` (ratio 1 to 128). The first toggle comes 2^N ticks after release.
- R6: The source is `pll_tick_i` when the mode is PLL. In bypass mode it is `xtal_tick_i` when `xtal_sel_i` is high and `ref_tick_i` when it is low. `pll_mode_o` and `ref_sel_o` are registered copies of `pll_mode_i` and `xtal_sel_i`.
- R7: A change of `pll_mode_i` takes effect only at a toggle of `fout_o` or during master reset. The divide interval in progress finishes on the old source.
- R8: Serial mode becomes active after a serial load and ends at a parallel load. Outside serial mode `test_o` is 0.
- R9: In serial mode `test_o` shows a signal chosen by T: 0 gives the holding register's first-shifted bit, 1 gives the divider output, 2 gives the selected reference tick, and 3 gives a constant 1.
- R10: The synchronous power-on reset `rst` clears M, N, T, serial mode, the divider and all outputs to 0, except `fout_n_o`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| mr_i | input | 1 | Master reset of the divider, active high |
| pll_mode_i | input | 1 | 1 = PLL mode, 0 = bypass |
| xtal_sel_i | input | 1 | 1 = crystal reference, 0 = external reference |
| pll_tick_i | input | 1 | PLL clock tick, one cycle wide |
| xtal_tick_i | input | 1 | Crystal reference tick |
| ref_tick_i | input | 1 | External reference tick |
| pload_n_i | input | 1 | Parallel load strobe, active low, captures on rising edge |
| m_i | input | 9 | Parallel M value |
| n_i | input | 3 | Parallel N code |
| sclk_i | input | 1 | Serial shift clock |
| sdata_i | input | 1 | Serial data |
| sload_i | input | 1 | Serial transfer control, acts on rising edge |
| fout_o | output | 1 | Divided output |
| fout_n_o | output | 1 | Complement of divided output |
| test_o | output | 1 | Test observation output |
| ref_sel_o | output | 1 | Registered reference select |
| pll_mode_o | output | 1 | Registered mode select |
| m_o | output | 9 | Loaded M value |
| n_o | output | 3 | Loaded N code |
| t_o | output | 2 | Loaded T selector |

## Verification
Several rules are checked by assertions on every cycle:
- the configuration moves only on a load event;
- a parallel load ends serial mode;
- master reset clears the divider state;
- the counter restarts at each wrap;
- the active source changes only at a wrap or under master reset;
- the test output stays low outside serial mode.

Other behaviours need the bench's scenarios:
- the frame bit order and the absolute divide intervals for each N;
- the choice among the three tick sources;
- the test output's value for a given T;
- the finishing of an interval on the old source after a mode change.

// File: rtl/cfg_synth_pkg.sv
package cfg_synth_pkg;
  localparam int TSEL_W = 2;

  typedef enum logic [TSEL_W-1:0] {
    TSEL_SHIFT_HEAD = 2'd0,
    TSEL_DIV_OUT    = 2'd1,
    TSEL_REF_TICK   = 2'd2,
    TSEL_CONST_HI   = 2'd3
  } test_sel_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int          WIDTH  = 4,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar gs;
  generate
    for (gs = 0; gs < STAGES; gs++) begin : g_stage
      if (gs == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[gs] <= IDLE;
          else     stage_q[gs] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stage_q[gs] <= IDLE;
          else     stage_q[gs] <= stage_q[gs-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int M_W = 9,
  parameter int N_W = 3,
  parameter int T_W = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_ev,
  input  logic [M_W-1:0] m_pin,
  input  logic [N_W-1:0] n_pin,
  input  logic           shift_ev,
  input  logic           shift_bit,
  input  logic           xfer_ev,
  output logic [M_W-1:0] m_q,
  output logic [N_W-1:0] n_q,
  output logic [T_W-1:0] t_q,
  output logic           serial_mode,
  output logic           shift_head
);
  localparam int FRAME_W = T_W + N_W + M_W;

  logic [FRAME_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)           hold_q <= '0;
    else if (shift_ev) hold_q <= {hold_q[FRAME_W-2:0], shift_bit};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q         <= '0;
      n_q         <= '0;
      t_q         <= '0;
      serial_mode <= 1'b0;
    end else if (par_ev) begin
      m_q         <= m_pin;
      n_q         <= n_pin;
      serial_mode <= 1'b0;
    end else if (xfer_ev) begin
      {t_q, n_q, m_q} <= hold_q;
      serial_mode     <= 1'b1;
    end
  end

  assign shift_head = hold_q[FRAME_W-1];

  AST_CFG_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    !(par_ev || xfer_ev) |=> $stable({t_q, n_q, m_q})); // R3
  AST_PAR_ENDS_SERIAL: assert property (@(posedge clk) disable iff (rst)
    par_ev |=> !serial_mode); // R8
  AST_XFER_STARTS_SERIAL: assert property (@(posedge clk) disable iff (rst)
    (xfer_ev && !par_ev) |=> serial_mode); // R8
endmodule

// File: rtl/cfg_out_div.sv
module cfg_out_div #(
  parameter int N_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mr,
  input  logic [N_W-1:0] n_code,
  input  logic           mode_pll,
  input  logic           pll_tick,
  input  logic           ref_tick,
  output logic           div_q,
  output logic           wrap
);
  localparam int CNT_W = (1 << N_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             act_pll_q;
  logic             src_tick;

  always_comb begin
    limit = '0;
    for (int i = 0; i < CNT_W; i++)
      if (i < int'(n_code)) limit[i] = 1'b1;
  end

  assign src_tick = act_pll_q ? pll_tick : ref_tick;
  assign wrap     = src_tick && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || mr) begin
      cnt_q     <= '0;
      div_q     <= 1'b0;
      act_pll_q <= mode_pll;
    end else if (src_tick) begin
      if (cnt_q >= limit) begin
        cnt_q     <= '0;
        div_q     <= ~div_q;
        act_pll_q <= mode_pll;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_MR_CLEARS_DIV: assert property (@(posedge clk) disable iff (rst)
    mr |=> (!div_q && cnt_q == '0)); // R4
  AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (wrap && !mr) |=> (cnt_q == '0)); // R5
  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !(wrap || mr) |=> $stable(act_pll_q)); // R7
endmodule

// File: rtl/cfg_synth_loader.sv
module cfg_synth_loader
  import cfg_synth_pkg::*;
#(
  parameter int M_W         = 9,
  parameter int N_W         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mr_i,
  input  logic           pll_mode_i,
  input  logic           xtal_sel_i,
  input  logic           pll_tick_i,
  input  logic           xtal_tick_i,
  input  logic           ref_tick_i,
  input  logic           pload_n_i,
  input  logic [M_W-1:0] m_i,
  input  logic [N_W-1:0] n_i,
  input  logic           sclk_i,
  input  logic           sdata_i,
  input  logic           sload_i,
  output logic           fout_o,
  output logic           fout_n_o,
  output logic           test_o,
  output logic           ref_sel_o,
  output logic           pll_mode_o,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [TSEL_W-1:0] t_o
);
  localparam int         CTL_W    = 4;
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1000;

  logic [CTL_W-1:0] ctl_s, ctl_prev;
  logic par_ev, shift_ev, xfer_ev;
  logic serial_mode, shift_head;
  logic div_q, wrap;
  logic ref_src;

  cfg_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .IDLE(CTL_IDLE)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({pload_n_i, sclk_i, sdata_i, sload_i}),
    .sync_o  (ctl_s)
  );

  always_ff @(posedge clk) begin
    if (rst) ctl_prev <= CTL_IDLE;
    else     ctl_prev <= ctl_s;
  end

  assign par_ev   = ctl_s[3] & ~ctl_prev[3];
  assign shift_ev = ctl_s[2] & ~ctl_prev[2];
  assign xfer_ev  = ctl_s[0] & ~ctl_prev[0];

  cfg_loader #(.M_W(M_W), .N_W(N_W), .T_W(TSEL_W)) u_loader (
    .clk         (clk),
    .rst         (rst),
    .par_ev      (par_ev),
    .m_pin       (m_i),
    .n_pin       (n_i),
    .shift_ev    (shift_ev),
    .shift_bit   (ctl_s[1]),
    .xfer_ev     (xfer_ev),
    .m_q         (m_o),
    .n_q         (n_o),
    .t_q         (t_o),
    .serial_mode (serial_mode),
    .shift_head  (shift_head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sel_o  <= 1'b0;
      pll_mode_o <= 1'b0;
    end else begin
      ref_sel_o  <= xtal_sel_i;
      pll_mode_o <= pll_mode_i;
    end
  end

  assign ref_src = ref_sel_o ? xtal_tick_i : ref_tick_i;

  cfg_out_div #(.N_W(N_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .mr       (mr_i),
    .n_code   (n_o),
    .mode_pll (pll_mode_o),
    .pll_tick (pll_tick_i),
    .ref_tick (ref_src),
    .div_q    (div_q),
    .wrap     (wrap)
  );

  assign fout_o   = div_q;
  assign fout_n_o = ~div_q;

  always_ff @(posedge clk) begin
    if (rst || !serial_mode) test_o <= 1'b0;
    else begin
      unique case (test_sel_e'(t_o))
        TSEL_SHIFT_HEAD: test_o <= shift_head;
        TSEL_DIV_OUT:    test_o <= div_q;
        TSEL_REF_TICK:   test_o <= ref_src;
        TSEL_CONST_HI:   test_o <= 1'b1;
      endcase
    end
  end

  AST_TEST_LOW_PARALLEL: assert property (@(posedge clk) disable iff (rst)
    !serial_mode |=> !test_o); // R8
  AST_MR_HOLDS_PAIR: assert property (@(posedge clk) disable iff (rst)
    $past(mr_i) |-> (!fout_o && fout_n_o)); // R4
endmodule

// File: tb/cfg_synth_loader_test.sv
module cfg_synth_loader_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mr = 1'b0, pll_mode = 1'b1, xtal_sel = 1'b0;
  logic pll_tick = 1'b1, xtal_tick = 1'b0, ref_tick = 1'b0;
  logic pload_n = 1'b1, sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
  logic [8:0] m_in = '0;
  logic [2:0] n_in = '0;
  logic fout, fout_n, test_out, ref_sel, mode_out;
  logic [8:0] m_out;
  logic [2:0] n_out;
  logic [1:0] t_out;

  int checks = 0, errors = 0;
  int xdiv = 0, rdiv = 0, cyc = 0;

  always #2.5 clk = ~clk;

  cfg_synth_loader uut (
    .clk(clk), .rst(rst), .mr_i(mr), .pll_mode_i(pll_mode), .xtal_sel_i(xtal_sel),
    .pll_tick_i(pll_tick), .xtal_tick_i(xtal_tick), .ref_tick_i(ref_tick),
    .pload_n_i(pload_n), .m_i(m_in), .n_i(n_in), .sclk_i(sclk), .sdata_i(sdata),
    .sload_i(sload), .fout_o(fout), .fout_n_o(fout_n), .test_o(test_out),
    .ref_sel_o(ref_sel), .pll_mode_o(mode_out), .m_o(m_out), .n_o(n_out), .t_o(t_out)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    xtal_tick <= (xdiv != 0) && ((cyc % xdiv) == 0);
    ref_tick  <= (rdiv != 0) && ((cyc % rdiv) == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic par_load(input logic [8:0] m, input logic [2:0] n);
    @(negedge clk); m_in = m; n_in = n; pload_n = 1'b0;
    repeat (5) @(negedge clk); pload_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    sdata = b;
    repeat (2) @(negedge clk); sclk = 1'b1;
    repeat (4) @(negedge clk); sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic shift_frame(input logic [13:0] f);
    for (int b = 13; b >= 0; b--) shift_bit(f[b]);
  endtask

  task automatic ser_load();
    sload = 1'b1; repeat (5) @(negedge clk);
    sload = 1'b0; repeat (8) @(negedge clk);
  endtask

  // cycles until fout changes, sampled at negedge
  task automatic wait_toggle(output int n, input int lim);
    logic prev = fout;
    n = 0;
    while (n < lim) begin
      @(negedge clk); n++;
      if (fout != prev) return;
    end
  endtask

  task automatic pulse_mr();
    @(negedge clk); mr = 1'b1;
    repeat (3) @(negedge clk);
    check(!fout && fout_n, "R4 pair under reset", {fout, fout_n}, 1);
    mr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(m_out == 0 && n_out == 0 && t_out == 0, "R10 config cleared", {t_out, n_out, m_out}, 0);
    check(!fout && fout_n && !test_out, "R10 outputs", {fout, fout_n, test_out}, 2);

    // R1 parallel sweep
    for (int i = 0; i < 16; i++) begin
      logic [8:0] m = 9'((i * 37 + 5) & 9'h1ff);
      par_load(m, 3'(i));
      check(m_out == m && n_out == 3'(i) && t_out == 0, "R1 parallel capture",
            {t_out, n_out, m_out}, {2'b00, 3'(i), m});
      check(!test_out, "R8 test low in parallel", test_out, 0);
    end

    // R2 serial frames
    for (int i = 0; i < 12; i++) begin
      logic [1:0] t = 2'(i);
      logic [2:0] n = 3'(i * 3);
      logic [8:0] m = 9'((i * 83 + 17) & 9'h1ff);
      shift_frame({t, n, m});
      ser_load();
      check({t_out, n_out, m_out} == {t, n, m}, "R2 serial frame",
            {t_out, n_out, m_out}, {t, n, m});
    end

    // R9 constant high, R3 shifting without load
    shift_frame({2'd3, 3'd1, 9'h0f0});
    ser_load();
    check(test_out == 1'b1, "R9 T=3 high", test_out, 1);
    shift_frame({2'd0, 3'd5, 9'h1aa});
    ser_load();
    // T=0: head bit of holding register; shift 14 bits starting with 1
    shift_frame(14'b10_000_000000000);
    check({t_out, n_out, m_out} == {2'd0, 3'd5, 9'h1aa}, "R3 no load no change",
          {t_out, n_out, m_out}, {2'd0, 3'd5, 9'h1aa});
    check(test_out == 1'b1, "R9 T=0 shows head bit", test_out, 1);
    shift_bit(1'b0);
    check(test_out == 1'b0, "R9 T=0 head after shift", test_out, 0);
    par_load(9'h033, 3'd2);
    check(!test_out, "R8 parallel ends serial mode", test_out, 0);

    // R5 divider sweep in PLL mode
    pll_mode = 1'b1; pll_tick = 1'b1;
    for (int n = 0; n < 8; n++) begin
      par_load(9'h100 + 9'(n), 3'(n));
      pulse_mr();
      check(m_out == 9'h100 + 9'(n) && n_out == 3'(n), "R4 config kept", m_out, 9'h100 + n);
      wait_toggle(d, 400);
      check(d == (1 << n), "R5 first toggle", d, 1 << n);
      wait_toggle(d, 400);
      check(d == (1 << n), "R5 steady toggle", d, 1 << n);
    end

    // R6 bypass sources
    par_load(9'h011, 3'd2);
    pll_mode = 1'b0; xtal_sel = 1'b1; xdiv = 2; rdiv = 0;
    repeat (2) @(negedge clk);
    check(!mode_out && ref_sel, "R6 mirrored selects", {mode_out, ref_sel}, 1);
    pulse_mr();
    wait_toggle(d, 400); wait_toggle(d, 400);
    check(d == 8, "R6 crystal tick source", d, 8);
    xtal_sel = 1'b0; xdiv = 0; rdiv = 4;
    pulse_mr();
    wait_toggle(d, 400); wait_toggle(d, 400);
    check(d == 16, "R6 external tick source", d, 16);

    // R7 mode change waits for boundary
    rdiv = 0; xdiv = 0; pll_mode = 1'b1;
    par_load(9'h011, 3'd7);
    pulse_mr();
    wait_toggle(d, 400);
    repeat (10) @(negedge clk);
    pll_mode = 1'b0;
    wait_toggle(d, 400);
    check(d == 118, "R7 interval finishes on PLL", d, 118);
    wait_toggle(d, 300);
    check(d == 300, "R7 bypass without ticks holds", d, 300);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule